// File: doc/BRIEF.md
# Eight-Operation ALU with Compare Flags

This block is a small arithmetic logic unit for unsigned operands. A 3-bit operation code picks one of eight results: either operand passed through unchanged, a bitwise AND or OR, a sum, a difference, the larger operand or the smaller operand. The result is returned on `z_o`. A 3-bit flag vector `f_o` carries the carry or borrow of the arithmetic operations. For the two selection operations, it also reports whether operand A won the comparison.

Operand width is set by a parameter, with a default of 4 bits; the block also works at 8 bits. When the `REGISTERED` parameter is 1 (the default), result and flags are captured on the rising clock edge and cleared by a synchronous active-low reset. When it is 0, the block is purely combinational and the clock and reset pins are unused. Flag bits that carry no meaning for the current operation are always 0.

Top module: `cmp_alu`

## Requirements
- R1: Operation code 3'b000 outputs operand A on the result, with all flags 0.
- R2: Operation code 3'b001 outputs operand B on the result, with all flags 0.
- R3: Operation code 3'b010 outputs A AND B, and code 3'b011 outputs A OR B, bitwise, with all flags 0.
- R4: Operation code 3'b100 outputs (A + B) mod 2^WIDTH. Flag bit 2 holds the carry out of the sum, and flag bits 1 and 0 are 0.
- R5: Operation code 3'b101 outputs (A − B) mod 2^WIDTH. Flag bit 2 is the borrow, which is 1 exactly when B > A (unsigned), and flag bits 1 and 0 are 0.
- R6: Operation code 3'b110 outputs the larger operand. Flag bit 1 is 1 when A is the one selected, and flag bits 2 and 0 are 0.
- R7: Operation code 3'b111 outputs the smaller operand. Flag bit 0 is 1 when A is the one selected, and flag bits 2 and 1 are 0.
- R8: When A equals B, codes 3'b110 and 3'b111 both output A, with flag bit 1 (for 3'b110) or flag bit 0 (for 3'b111) set to 1.
- R9: With REGISTERED=1, result and flags change only at a rising clock edge and reflect the inputs present just before that edge. While rst_n is low at an edge, both are cleared to 0.
- R10: At most one flag bit is set at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register (unused when REGISTERED=0) |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| op_i | input | 3 | Operation code |
| a_i | input | WIDTH | Operand A, unsigned |
| b_i | input | WIDTH | Operand B, unsigned |
| z_o | output | WIDTH | Result |
| f_o | output | 3 | Flags: bit 2 carry/borrow, bit 1 A is larger, bit 0 A is smaller |

## Verification
The assertions assume that the operation code and both operands are known (not X or Z) during every clock cycle outside reset. In registered mode, they also assume these inputs are held stable across the sampling edge, because each output is compared with the inputs captured one edge earlier. The bench meets both assumptions by driving every input on the falling edge only, and by setting defined values before reset is released. It then walks all eight operation codes over every pair of 4-bit operands. This covers equal operands, all-ones plus one, and zero minus one.

// File: rtl/cmp_alu_pkg.sv
// Package: shared operation codes and flag bit positions for the ALU.
// Assumes: the flag vector is 3 bits, and its bit positions are fixed by the interface.
package cmp_alu_pkg;

    typedef enum logic [2:0] {
        OP_MOVA = 3'b000,
        OP_MOVB = 3'b001,
        OP_AND  = 3'b010,
        OP_OR   = 3'b011,
        OP_ADD  = 3'b100,
        OP_SUB  = 3'b101,
        OP_MAX  = 3'b110,
        OP_MIN  = 3'b111
    } alu_op_e;

    localparam int FLAG_W     = 3;
    localparam int FLG_CARRY  = 2;
    localparam int FLG_A_BIG  = 1;
    localparam int FLG_A_SML  = 0;

endpackage

// File: rtl/cmp_alu_addsub.sv
// Module: unsigned adder and subtractor, built side by side.
// Assumes: operands are unsigned. The extra top bit of each result is the carry for the sum
// and the borrow for the difference.
module cmp_alu_addsub #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum,
    output logic             carry,
    output logic [WIDTH-1:0] diff,
    output logic             borrow
);
    localparam int EXT_W = WIDTH + 1;

    logic [EXT_W-1:0] sum_ext;
    logic [EXT_W-1:0] diff_ext;

    // Purpose: form the widened sum and difference. The top bit is the carry or borrow.
    always_comb begin
        sum_ext  = {1'b0, a} + {1'b0, b};
        diff_ext = {1'b0, a} - {1'b0, b};
    end

    assign sum    = sum_ext[WIDTH-1:0];
    assign carry  = sum_ext[WIDTH];
    assign diff   = diff_ext[WIDTH-1:0];
    assign borrow = diff_ext[WIDTH];

endmodule

// File: rtl/cmp_alu_compare.sv
// Module: picks the larger and the smaller operand, reusing the subtractor borrow.
// Assumes: borrow is 1 exactly when b > a (unsigned). On a tie, A is taken as both larger and smaller.
module cmp_alu_compare #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             borrow,
    output logic [WIDTH-1:0] larger,
    output logic [WIDTH-1:0] smaller,
    output logic             a_is_larger,
    output logic             a_is_smaller
);
    logic equal;

    // Purpose: derive the tie detect and the two "A wins" decisions.
    always_comb begin
        equal        = (a == b);
        a_is_larger  = ~borrow;
        a_is_smaller = borrow | equal;
    end

    // Purpose: steer the operands to the max and min outputs.
    always_comb begin
        larger  = a_is_larger  ? a : b;
        smaller = a_is_smaller ? a : b;
    end

endmodule

// File: rtl/cmp_alu_resmux.sv
// Module: selects the result and builds the flag vector from the operation code.
// Assumes: flag bits that mean nothing for the chosen operation must be 0.
module cmp_alu_resmux
    import cmp_alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [2:0]       op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] sum,
    input  logic             carry,
    input  logic [WIDTH-1:0] diff,
    input  logic             borrow,
    input  logic [WIDTH-1:0] larger,
    input  logic [WIDTH-1:0] smaller,
    input  logic             a_is_larger,
    input  logic             a_is_smaller,
    output logic [WIDTH-1:0] z,
    output logic [FLAG_W-1:0] f
);
    // Purpose: a single decode of the operation code into result and flags.
    always_comb begin
        z = '0;
        f = '0;
        case (alu_op_e'(op))
            OP_MOVA: z = a;
            OP_MOVB: z = b;
            OP_AND:  z = a & b;
            OP_OR:   z = a | b;
            OP_ADD: begin
                z            = sum;
                f[FLG_CARRY] = carry;
            end
            OP_SUB: begin
                z            = diff;
                f[FLG_CARRY] = borrow;
            end
            OP_MAX: begin
                z            = larger;
                f[FLG_A_BIG] = a_is_larger;
            end
            OP_MIN: begin
                z            = smaller;
                f[FLG_A_SML] = a_is_smaller;
            end
            default: begin
                z = '0;
                f = '0;
            end
        endcase
    end

endmodule

// File: rtl/cmp_alu_outstage.sv
// Module: output stage, either a register or a straight wire, chosen by REGISTERED.
// Assumes: the reset is synchronous and active low. In the wire variant, clk and rst_n are unused.
module cmp_alu_outstage #(
    parameter int WIDTH      = 4,
    parameter int FW         = 3,
    parameter bit REGISTERED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] z_d,
    input  logic [FW-1:0]    f_d,
    output logic [WIDTH-1:0] z_q,
    output logic [FW-1:0]    f_q
);
    generate
        if (REGISTERED) begin : g_reg
            // Purpose: capture result and flags on each rising edge; clear them under reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    z_q <= '0;
                    f_q <= '0;
                end else begin
                    z_q <= z_d;
                    f_q <= f_d;
                end
            end
        end else begin : g_comb
            logic unused_ok;
            assign unused_ok = clk ^ rst_n;
            assign z_q = z_d;
            assign f_q = f_d;
        end
    endgenerate

endmodule

// File: rtl/cmp_alu.sv
// Module: top level of the eight-operation unsigned ALU with compare flags.
// Assumes: unsigned operands of WIDTH bits. REGISTERED chooses between a clocked output and a purely
// combinational one.
module cmp_alu
    import cmp_alu_pkg::*;
#(
    parameter int WIDTH      = 4,
    parameter bit REGISTERED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] z_o,
    output logic [2:0]       f_o
);
    logic [WIDTH-1:0]  sum, diff, larger, smaller, z_next;
    logic              carry, borrow, a_big, a_sml;
    logic [FLAG_W-1:0] f_next;

    cmp_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a(a_i), .b(b_i), .sum(sum), .carry(carry), .diff(diff), .borrow(borrow)
    );

    cmp_alu_compare #(.WIDTH(WIDTH)) u_compare (
        .a(a_i), .b(b_i), .borrow(borrow), .larger(larger), .smaller(smaller),
        .a_is_larger(a_big), .a_is_smaller(a_sml)
    );

    cmp_alu_resmux #(.WIDTH(WIDTH)) u_resmux (
        .op(op_i), .a(a_i), .b(b_i), .sum(sum), .carry(carry), .diff(diff),
        .borrow(borrow), .larger(larger), .smaller(smaller),
        .a_is_larger(a_big), .a_is_smaller(a_sml), .z(z_next), .f(f_next)
    );

    cmp_alu_outstage #(.WIDTH(WIDTH), .FW(FLAG_W), .REGISTERED(REGISTERED)) u_out (
        .clk(clk), .rst_n(rst_n), .z_d(z_next), .f_d(f_next), .z_q(z_o), .f_q(f_o)
    );

endmodule

// File: rtl/cmp_alu_checker.sv
// Module: property checker for cmp_alu, attached to it by the bind statement below.
// Assumes: inputs are known outside reset. In registered mode each output is compared with the
// inputs the checker captured at the previous edge.
module cmp_alu_checker #(
    parameter int WIDTH      = 4,
    parameter bit REGISTERED = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       op_i,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [WIDTH-1:0] z_o,
    input logic [2:0]       f_o
);
    logic [2:0]       op_s;
    logic [WIDTH-1:0] a_s, b_s;
    logic             vld;
    logic [WIDTH:0]   sum_ref;

    generate
        if (REGISTERED) begin : g_reg
            // Purpose: hold the inputs the output register saw at the previous edge.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld  <= 1'b0;
                    op_s <= '0;
                    a_s  <= '0;
                    b_s  <= '0;
                end else begin
                    vld  <= 1'b1;
                    op_s <= op_i;
                    a_s  <= a_i;
                    b_s  <= b_i;
                end
            end
        end else begin : g_comb
            assign vld  = 1'b1;
            assign op_s = op_i;
            assign a_s  = a_i;
            assign b_s  = b_i;
        end
    endgenerate

    assign sum_ref = {1'b0, a_s} + {1'b0, b_s};

    a_r1_move_a: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && op_s == 3'b000) |-> (z_o == a_s && f_o == 3'b000));

    a_r2_move_b: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && op_s == 3'b001) |-> (z_o == b_s && f_o == 3'b000));

    a_r3_logic: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && op_s[2:1] == 2'b01) |->
        (z_o == (op_s[0] ? (a_s | b_s) : (a_s & b_s)) && f_o == 3'b000));

    a_r4_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && op_s == 3'b100) |-> ({f_o[2], z_o} == sum_ref && f_o[1:0] == 2'b00));

    a_r5_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && op_s == 3'b101) |->
        (f_o[2] == (b_s > a_s) && z_o + b_s == a_s && f_o[1:0] == 2'b00));

    a_r6_larger: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && op_s == 3'b110) |->
        (z_o >= a_s && z_o >= b_s && f_o[1] == (a_s >= b_s) && f_o[2] == 1'b0 && f_o[0] == 1'b0));

    a_r7_smaller: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && op_s == 3'b111) |->
        (z_o <= a_s && z_o <= b_s && f_o[0] == (a_s <= b_s) && f_o[2:1] == 2'b00));

    a_r8_tie: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && op_s[2:1] == 2'b11 && a_s == b_s) |-> (z_o == a_s && f_o != 3'b000));

    a_r10_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> $onehot0(f_o));

endmodule

bind cmp_alu cmp_alu_checker #(.WIDTH(WIDTH), .REGISTERED(REGISTERED)) i_cmp_alu_checker (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i), .z_o(z_o), .f_o(f_o)
);

// File: tb/test_cmp_alu.sv
`timescale 1ns/1ps
module test_cmp_alu;
    localparam int W    = 4;
    localparam int MASK = (1 << W) - 1;

    typedef struct {
        int op;
        int a;
        int b;
        int ez;
        int ef;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   op_i = '0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic [W-1:0] z_o;
    logic [2:0]   f_o;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    cmp_alu #(.WIDTH(W), .REGISTERED(1'b1)) i_cmp_alu (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i), .z_o(z_o), .f_o(f_o)
    );

    function automatic string req_of(int op, int a, int b);
        if (op >= 6 && a == b) return "R8";
        case (op)
            0: return "R1";
            1: return "R2";
            2, 3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string req, int act_z, int exp_z, int act_f, int exp_f);
        checks++;
        if (act_z != exp_z || act_f != exp_f) begin
            errors++;
            $display("FAIL %s: actual z=%0d f=%b expected z=%0d f=%b",
                     req, act_z, act_f[2:0], exp_z, exp_f[2:0]);
        end
    endtask

    // Driver: apply one operation on the falling edge and queue its expected outcome.
    task automatic drive(int op, int a, int b);
        exp_t e;
        e.op = op; e.a = a; e.b = b; e.ef = 0;
        case (op)
            0: e.ez = a;
            1: e.ez = b;
            2: e.ez = a & b;
            3: e.ez = a | b;
            4: begin e.ez = (a + b) & MASK; e.ef = ((a + b) > MASK) ? 4 : 0; end
            5: begin e.ez = (a - b) & MASK; e.ef = (b > a) ? 4 : 0; end
            6: begin e.ez = (a >= b) ? a : b; e.ef = (a >= b) ? 2 : 0; end
            default: begin e.ez = (a <= b) ? a : b; e.ef = (a <= b) ? 1 : 0; end
        endcase
        @(negedge clk);
        op_i = op[2:0];
        a_i  = a[W-1:0];
        b_i  = b[W-1:0];
        sb_q.push_back(e);
    endtask

    // Monitor: one step after each rising edge, compare the registered output with the oldest entry.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(req_of(e.op, e.a, e.b), int'(z_o), e.ez, int'(f_o), e.ef);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(100000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R9: while reset is held, outputs read 0 even with nonzero operands applied.
        op_i = 3'b100; a_i = 4'hF; b_i = 4'hF;
        repeat (3) @(posedge clk);
        #1;
        check("R9", int'(z_o), 0, int'(f_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Edge cases first: all-ones plus one (R4), zero minus one (R5), and ties (R8).
        drive(4, MASK, 1);
        drive(5, 0, 1);
        drive(6, 9, 9);
        drive(7, 9, 9);
        drive(4, 0, 0);

        // Every operation over every pair of operands (R1 to R8).
        for (int op = 0; op < 8; op++)
            for (int a = 0; a <= MASK; a++)
                for (int b = 0; b <= MASK; b++)
                    drive(op, a, b);
        @(posedge clk);
        #1;
        wait (sb_q.size() == 0);

        // R9: the output holds until the rising edge, then takes the new result.
        // The last operation above was 3'b111 with A=B=15, which gives z=15 and f=001.
        @(negedge clk);
        op_i = 3'b010; a_i = '0; b_i = 4'hF;
        #1;
        check("R9", int'(z_o), MASK, int'(f_o), 1);
        @(posedge clk);
        #1;
        check("R9", int'(z_o), 0, int'(f_o), 0);

        // R9: a synchronous reset clears a nonzero result at the next edge.
        @(negedge clk);
        op_i = 3'b100; a_i = 4'hF; b_i = 4'h3;
        @(posedge clk);
        #1;
        check("R4", int'(z_o), 2, int'(f_o), 4);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9", int'(z_o), 2, int'(f_o), 4);
        @(posedge clk);
        #1;
        check("R9", int'(z_o), 0, int'(f_o), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule